// File: doc/BRIEF.md
# Host-to-CPU Doorbell Interrupt Register

This block holds two flag bits that let an external host and a local processor signal each other. The doorbell flag is raised by the host and lowered by the processor. Raising it from zero emits a single-cycle interrupt pulse to the processor. Once the doorbell is pending, further host writes neither change it nor pulse again until the processor acknowledges it. The host reads the flag back and waits for zero before ringing again.

The return flag works the other way round. The processor raises it, the host lowers it, and its level drives an interrupt line toward the host. Host writes are accepted only when the host's control-select lines carry the code that addresses this register. Both sides read both flags without disturbing them. An asynchronous active-low reset clears everything at once.

Top module: `hostcpu_doorbell`

## Requirements
- R1: A host write (host_we=1, host_sel equal to CTRL_CODE, default 2'b00) with data bit DB_POS (default bit 0) at 1, while the doorbell flag is 0, sets the flag. At the same clock edge the registered pulse output cpu_irq_pulse rises.
- R2: While the doorbell flag is 1 and the processor is not clearing it, host writes with data bit DB_POS at 0 or 1 leave the flag at 1 and produce no pulse.
- R3: A processor write (cpu_we=1) with data bit DB_POS at 1 forces a set doorbell flag to 0 at the next edge.
- R4: Writes of 0 in a flag's bit position, from either port, never change that flag.
- R5: Driving rst_n low clears both flags, the pulse and the host interrupt at once, without waiting for a clock edge.
- R6: Host writes whose select code differs from CTRL_CODE change neither flag and produce no pulse.
- R7: If a host set and a processor clear of the doorbell arrive at the same edge, the flag ends at 0 when it was 1. When it was 0, the flag ends at 1 and the pulse fires.
- R8: cpu_irq_pulse is high for exactly one clock cycle per doorbell set.
- R9: The return flag (bit HB_POS, default bit 1) is set by a processor write of 1 and cleared by a selected host write of 1. When both arrive together, the clear wins if the flag is 1 and the set wins if it is 0. host_irq equals the flag level.
- R10: host_rdata and cpu_rdata both show the doorbell in bit DB_POS and the return flag in bit HB_POS, with all other bits 0. Reading has no effect on either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | SEL_W | Host control-select code |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write data |
| cpu_we | input | 1 | Processor write strobe |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_irq_pulse | output | 1 | One-cycle interrupt pulse to the processor |
| host_irq | output | 1 | Level interrupt to the host |
| host_rdata | output | DATA_W | Host read-back of both flags |
| cpu_rdata | output | DATA_W | Processor read-back of both flags |

## Verification
The bench builds the block with its defaults: a 2-bit select, a 2-bit data word, the doorbell at bit 0 and the return flag at bit 1. At this size, every input combination of a single cycle fits in 256 values: select code, host strobe, both host data bits, processor strobe and both processor data bits. The bench applies each of them from each of the four starting states of the flag pair. This reaches every collision case, every ignored select code and every zero write. The cycle after each applied combination is also checked, to confirm that the pulse has dropped and that the flags hold.

// File: rtl/hd_pkg.sv
package hd_pkg;
   // one set/clear request pair for a single flag
   typedef struct packed {
      logic set;
      logic clr;
   } flag_evt_t;

   // next value of a set/clear flag: when set, a clear wins; when clear, a set wins
   function automatic logic flag_next(input logic cur, input flag_evt_t ev);
      return cur ? !ev.clr : ev.set;
   endfunction
endpackage

// File: rtl/hd_host_decode.sv
module hd_host_decode
   import hd_pkg::*;
#(
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned CTRL_CODE = 0,
   parameter int unsigned DATA_W    = 2,
   parameter int unsigned DB_POS    = 0,
   parameter int unsigned HB_POS    = 1
) (
   input  logic [SEL_W-1:0]  host_sel,
   input  logic              host_we,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              cpu_we,
   input  logic [DATA_W-1:0] cpu_wdata,
   output flag_evt_t         db_evt,
   output flag_evt_t         hb_evt
);
   localparam logic [SEL_W-1:0] SEL_HIT = SEL_W'(CTRL_CODE);

   logic host_hit;
   assign host_hit = host_we && (host_sel == SEL_HIT);

   // doorbell: host raises, processor acknowledges
   assign db_evt.set = host_hit && host_wdata[DB_POS];
   assign db_evt.clr = cpu_we && cpu_wdata[DB_POS];
   // return flag: processor raises, host acknowledges
   assign hb_evt.set = cpu_we && cpu_wdata[HB_POS];
   assign hb_evt.clr = host_hit && host_wdata[HB_POS];
endmodule

// File: rtl/hd_flag.sv
module hd_flag
   import hd_pkg::*;
#(
   parameter bit PULSE_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  flag_evt_t evt,
   output logic      flag_o,
   output logic      pulse_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_next(flag_q, evt);
   end
   assign flag_o = flag_q;

   generate
      if (PULSE_EN) begin : g_pulse
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= !flag_q && evt.set;
         end
         assign pulse_o = pulse_q;

         // R8
         pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_q |=> !pulse_q);
         // R1
         rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q) |-> pulse_q);
         // R2
         pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !evt.clr) |=> (flag_q && !pulse_q));
      end else begin : g_level
         assign pulse_o = 1'b0;
      end
   endgenerate

   // R3
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && evt.clr) |=> !flag_q);
   // R4
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !evt.set) |=> !flag_q);
endmodule

// File: rtl/hd_readback.sv
module hd_readback #(
   parameter int unsigned DATA_W = 2,
   parameter int unsigned DB_POS = 0,
   parameter int unsigned HB_POS = 1
) (
   input  logic              db_flag,
   input  logic              hb_flag,
   output logic [DATA_W-1:0] rvec
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == DB_POS) begin : g_db
         assign rvec[i] = db_flag;
      end else if (i == HB_POS) begin : g_hb
         assign rvec[i] = hb_flag;
      end else begin : g_zero
         assign rvec[i] = 1'b0;
      end
   end
endmodule

// File: rtl/hostcpu_doorbell.sv
module hostcpu_doorbell
   import hd_pkg::*;
#(
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned CTRL_CODE = 0,
   parameter int unsigned DATA_W    = 2,
   parameter int unsigned DB_POS    = 0,
   parameter int unsigned HB_POS    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  host_sel,
   input  logic              host_we,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              cpu_we,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_irq_pulse,
   output logic              host_irq,
   output logic [DATA_W-1:0] host_rdata,
   output logic [DATA_W-1:0] cpu_rdata
);
   localparam logic [SEL_W-1:0] SEL_HIT = SEL_W'(CTRL_CODE);

   initial begin
      sel_width_chk: assert (SEL_W >= 1 && SEL_W <= 8) else $error("SEL_W out of range");
      code_fit_chk: assert (CTRL_CODE < (1 << SEL_W)) else $error("CTRL_CODE does not fit SEL_W");
      pos_fit_chk: assert (DB_POS < DATA_W && HB_POS < DATA_W) else $error("bit position outside DATA_W");
      pos_distinct_chk: assert (DB_POS != HB_POS) else $error("flag positions overlap");
   end

   flag_evt_t db_evt, hb_evt;
   logic      db_flag, hb_flag, hb_pulse_unused;
   logic [DATA_W-1:0] rvec;

   hd_host_decode #(
      .SEL_W(SEL_W), .CTRL_CODE(CTRL_CODE), .DATA_W(DATA_W),
      .DB_POS(DB_POS), .HB_POS(HB_POS)
   ) u_decode (
      .host_sel(host_sel), .host_we(host_we), .host_wdata(host_wdata),
      .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
      .db_evt(db_evt), .hb_evt(hb_evt)
   );

   hd_flag #(.PULSE_EN(1'b1)) u_doorbell (
      .clk(clk), .rst_n(rst_n), .evt(db_evt),
      .flag_o(db_flag), .pulse_o(cpu_irq_pulse)
   );

   hd_flag #(.PULSE_EN(1'b0)) u_return (
      .clk(clk), .rst_n(rst_n), .evt(hb_evt),
      .flag_o(hb_flag), .pulse_o(hb_pulse_unused)
   );

   hd_readback #(.DATA_W(DATA_W), .DB_POS(DB_POS), .HB_POS(HB_POS)) u_rb (
      .db_flag(db_flag), .hb_flag(hb_flag), .rvec(rvec)
   );

   assign host_irq   = hb_flag;
   assign host_rdata = rvec;
   assign cpu_rdata  = rvec;

   // R6
   foreign_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!db_flag && !(host_we && host_sel == SEL_HIT)) |=> (!db_flag && !cpu_irq_pulse));
   // R9
   return_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_irq && cpu_we && cpu_wdata[HB_POS]) |=> host_irq);
   // R7
   collide_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!db_flag && host_we && host_sel == SEL_HIT && host_wdata[DB_POS]) |=> cpu_irq_pulse);
endmodule

// File: tb/test_hostcpu_doorbell.sv
`timescale 1ns/1ps
module test_hostcpu_doorbell;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] host_sel = '0;
   logic       host_we = 1'b0;
   logic [1:0] host_wdata = '0;
   logic       cpu_we = 1'b0;
   logic [1:0] cpu_wdata = '0;
   logic       cpu_irq_pulse, host_irq;
   logic [1:0] host_rdata, cpu_rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   hostcpu_doorbell i_hostcpu_doorbell (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
      .host_wdata(host_wdata), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
      .cpu_irq_pulse(cpu_irq_pulse), .host_irq(host_irq),
      .host_rdata(host_rdata), .cpu_rdata(cpu_rdata)
   );

   task automatic chk(input int act, input int exp, input string tag, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      host_sel = '0; host_we = 1'b0; host_wdata = '0;
      cpu_we = 1'b0; cpu_wdata = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); idle(); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   // expected outputs for the model state (db, hb)
   task automatic chk_all(input logic db, input logic hb, input logic pl,
                          input string dtag, input string ptag);
      chk(int'(host_rdata[0]), int'(db), dtag, "doorbell bit");
      chk(int'(host_rdata[1]), int'(hb), "R9", "return bit");
      chk(int'(host_irq), int'(hb), "R9", "host_irq level");
      chk(int'(cpu_rdata), int'({hb, db}), "R10", "cpu_rdata");
      chk(int'(cpu_irq_pulse), int'(pl), ptag, "pulse");
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R5: reset state
      #1;
      chk_all(1'b0, 1'b0, 1'b0, "R5", "R5");
      @(negedge clk); rst_n = 1'b1;

      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 256; c++) begin
            logic db, hb, hs, hc, cs, cc, hit, db_n, hb_n, pl;
            logic [7:0] cv;
            string dtag;
            cv = 8'(c);
            do_reset();
            db = s[0]; hb = s[1];
            // prepare the starting state in one cycle
            host_we = db; host_sel = 2'b00; host_wdata = 2'b01;
            cpu_we = hb; cpu_wdata = 2'b10;
            @(negedge clk);
            // apply the swept combination
            host_sel = cv[1:0]; host_we = cv[2]; host_wdata = cv[4:3];
            cpu_we = cv[5]; cpu_wdata = cv[7:6];
            hit = host_we && (host_sel == 2'b00);
            hs = hit && host_wdata[0];
            hc = hit && host_wdata[1];
            cc = cpu_we && cpu_wdata[0];
            cs = cpu_we && cpu_wdata[1];
            db_n = db ? !cc : hs;
            hb_n = hb ? !hc : cs;
            pl = !db && hs;
            if (hs && cc)                     dtag = "R7";
            else if (db && cc)                dtag = "R3";
            else if (db)                      dtag = "R2";
            else if (hs)                      dtag = "R1";
            else if (host_we && !hit)         dtag = "R6";
            else                              dtag = "R4";
            @(negedge clk);
            chk_all(db_n, hb_n, pl, dtag, dtag);
            // next cycle idle: pulse gone, flags held, reads side-effect free
            idle();
            @(negedge clk);
            chk_all(db_n, hb_n, 1'b0, "R10", "R8");
         end
      end

      // R5: asynchronous clear between edges with both flags set
      do_reset();
      host_we = 1'b1; host_sel = 2'b00; host_wdata = 2'b01;
      cpu_we = 1'b1; cpu_wdata = 2'b10;
      @(negedge clk); idle();
      #1.0 rst_n = 1'b0;
      #0.5;
      chk(int'(host_rdata), 0, "R5", "async clear rdata");
      chk(int'(host_irq), 0, "R5", "async clear host_irq");
      chk(int'(cpu_irq_pulse), 0, "R5", "async clear pulse");
      @(negedge clk); rst_n = 1'b1;

      // R8: repeated host rings produce exactly one pulse
      host_we = 1'b1; host_sel = 2'b00; host_wdata = 2'b01;
      @(negedge clk);
      chk(int'(cpu_irq_pulse), 1, "R8", "first ring pulse");
      @(negedge clk);
      chk(int'(cpu_irq_pulse), 0, "R8", "held ring no pulse");
      @(negedge clk);
      chk(int'(cpu_irq_pulse), 0, "R2", "third ring no pulse");
      idle();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule